// File: doc/BRIEF.md
# Counter Read Permission Gate

This block judges a single read of one of the user-visible counter CSRs: the cycle, wall-clock time and retired-instruction counters, the twenty-nine programmable event counters, and on 32-bit harts the upper-half registers of all of them. Every request presents a 12-bit CSR address together with a snapshot of the hart state. That snapshot holds the current privilege level, whether the hart runs a guest (virtualization on), the XLEN mode, whether the counter extension and supervisor mode are implemented, and three 32-bit counter-enable masks, one each for machine, hypervisor and supervisor.

One clock after the request strobe, exactly one of three outputs is high. `grantOk` lets the read proceed. `faultIllegal` asks for an illegal-instruction exception. `faultVirtual` asks for a virtual-instruction exception. The three masks are applied in a fixed order: machine, then hypervisor, then supervisor. The first mask that blocks the access decides the outcome. Addresses outside the two counter windows are passed through without checking.

Top module: `counter_access_gate`

## Requirements
- R1: The verdict is registered: it appears on the clock edge after the edge that samples `reqValid`=1, and exactly one of `grantOk`, `faultIllegal`, `faultVirtual` is then high. After a cycle with `reqValid`=0 all three are low. The synchronous active-high `rst` forces all three low.
- R2: When `hasCounters`=0, every counter address gives `faultIllegal`, whatever the masks or the privilege.
- R3: The low-half window is 0xC00 to 0xC1F. Its enable bit index is the address minus 0xC00: bit 0 is cycle, bit 1 is time, bit 2 is retired instructions, and bits 3 to 31 are the event counters.
- R4: The upper-half window is 0xC80 to 0xC9F. When `xlen32`=1, its enable bit index is the address minus 0xC80.
- R5: When `xlen32`=0, an upper-half address selects no enable bit. Below machine level it gives `faultIllegal`. At machine level it gives `grantOk`.
- R6: Privilege is encoded user=0, supervisor=1, machine=3; the value 2 counts as below machine and not as user. Below machine level, a clear selected bit in `mCountEn` gives `faultIllegal`, and this check takes precedence over the hypervisor and supervisor checks.
- R7: If the machine check passes, `virtOn`=1 and the selected bit of `hCountEn` is clear, the result is `faultVirtual`.
- R8: If the earlier checks pass, `hasSupervisor`=1, the privilege is user and the selected bit of `sCountEn` is clear, the result is `faultVirtual` when `virtOn`=1 and `faultIllegal` when `virtOn`=0. When `hasSupervisor`=0, `sCountEn` has no effect.
- R9: An address outside both counter windows always gives `grantOk`.
- R10: At machine level, `virtOn` has no effect, and an access to a counter with a mapped bit gives `grantOk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe |
| csrAddr | input | 12 | CSR address being read |
| privLevel | input | 2 | Current privilege level |
| virtOn | input | 1 | Hart runs in virtualized (guest) mode |
| xlen32 | input | 1 | Hart runs with 32-bit XLEN |
| hasCounters | input | 1 | Counter extension implemented |
| hasSupervisor | input | 1 | Supervisor mode implemented |
| mCountEn | input | 32 | Machine counter-enable mask |
| hCountEn | input | 32 | Hypervisor counter-enable mask |
| sCountEn | input | 32 | Supervisor counter-enable mask |
| grantOk | output | 1 | Access allowed |
| faultIllegal | output | 1 | Raise illegal instruction |
| faultVirtual | output | 1 | Raise virtual-instruction fault |

## Verification
The delicate cases are requests where two of the three masks block the access in the same request, so the priority alone picks the fault. With both machine and hypervisor bits clear in a guest, machine must win with an illegal instruction. With both hypervisor and supervisor bits clear for a guest user, the hypervisor fault must win. Sparse random masks (the AND of two random words) make these double blocks frequent across all 64 counter addresses, and directed requests force each pairing. Every response is compared against a behavioural model that walks the rules in order.

// File: rtl/ctr_gate_pkg.sv
package ctr_gate_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_R = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  // address decode and selected mask bits, datapath -> control
  typedef struct packed {
    logic inLow;
    logic inHigh;
    logic bitValid;
    logic mBit;
    logic hBit;
    logic sBit;
  } sel_t;

  // verdict strobes, control -> datapath
  typedef struct packed {
    logic load;
    logic allow;
    logic illegal;
    logic virtFault;
  } verdict_t;

endpackage

// File: rtl/ctrGateDatapath.sv
module ctrGateDatapath
  import ctr_gate_pkg::*;
#(
  parameter int CSR_W = 12,
  parameter int MASK_W = 32,
  parameter logic [CSR_W-1:0] LOW_BASE = 12'hC00,
  parameter logic [CSR_W-1:0] HIGH_BASE = 12'hC80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CSR_W-1:0] csrAddr,
  input  logic             xlen32,
  input  logic [MASK_W-1:0] mCountEn,
  input  logic [MASK_W-1:0] hCountEn,
  input  logic [MASK_W-1:0] sCountEn,
  input  verdict_t         strobe,
  output sel_t             selOut,
  output logic             grantOk,
  output logic             faultIllegal,
  output logic             faultVirtual
);
  localparam int IDX_W = $clog2(MASK_W);
  localparam logic [CSR_W-1:0] SPAN = CSR_W'(MASK_W);

  logic [CSR_W-1:0] offLow;
  logic [CSR_W-1:0] offHigh;
  logic             inLow;
  logic             inHigh;
  logic [IDX_W-1:0] bitIdx;
  logic             bitValid;

  assign offLow  = csrAddr - LOW_BASE;
  assign offHigh = csrAddr - HIGH_BASE;
  assign inLow   = (csrAddr >= LOW_BASE) && (offLow < SPAN);
  assign inHigh  = (csrAddr >= HIGH_BASE) && (offHigh < SPAN);

  always_comb begin
    if (inHigh) bitIdx = offHigh[IDX_W-1:0];
    else        bitIdx = offLow[IDX_W-1:0];
  end

  assign bitValid = inLow || (inHigh && xlen32);

  always_comb begin
    selOut.inLow    = inLow;
    selOut.inHigh   = inHigh;
    selOut.bitValid = bitValid;
    selOut.mBit     = bitValid && mCountEn[bitIdx];
    selOut.hBit     = bitValid && hCountEn[bitIdx];
    selOut.sBit     = bitValid && sCountEn[bitIdx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grantOk      <= 1'b0;
      faultIllegal <= 1'b0;
      faultVirtual <= 1'b0;
    end else if (strobe.load) begin
      grantOk      <= strobe.allow;
      faultIllegal <= strobe.illegal;
      faultVirtual <= strobe.virtFault;
    end else begin
      grantOk      <= 1'b0;
      faultIllegal <= 1'b0;
      faultVirtual <= 1'b0;
    end
  end

endmodule

// File: rtl/ctrGateControl.sv
module ctrGateControl
  import ctr_gate_pkg::*;
(
  input  logic       reqValid,
  input  logic [1:0] privLevel,
  input  logic       virtOn,
  input  logic       hasCounters,
  input  logic       hasSupervisor,
  input  sel_t       sel,
  output verdict_t   strobe
);
  logic  belowM;
  logic  isUser;
  logic  effVirt;
  logic  isCounter;
  priv_e priv;

  assign priv      = priv_e'(privLevel);
  assign belowM    = (priv != PRIV_M);
  assign isUser    = (priv == PRIV_U);
  assign effVirt   = virtOn && belowM;
  assign isCounter = sel.inLow || sel.inHigh;

  always_comb begin
    strobe = '0;
    strobe.load = reqValid;
    if (!isCounter) begin
      strobe.allow = 1'b1;
    end else if (!hasCounters) begin
      strobe.illegal = 1'b1;
    end else if (belowM && !sel.mBit) begin
      strobe.illegal = 1'b1;
    end else if (effVirt && !sel.hBit) begin
      strobe.virtFault = 1'b1;
    end else if (hasSupervisor && isUser && !sel.sBit) begin
      strobe.virtFault = effVirt;
      strobe.illegal   = !effVirt;
    end else begin
      strobe.allow = 1'b1;
    end
  end

endmodule

// File: rtl/counter_access_gate.sv
module counter_access_gate
  import ctr_gate_pkg::*;
#(
  parameter int CSR_W = 12,
  parameter int MASK_W = 32,
  parameter logic [CSR_W-1:0] LOW_BASE = 12'hC00,
  parameter logic [CSR_W-1:0] HIGH_BASE = 12'hC80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [CSR_W-1:0]  csrAddr,
  input  logic [1:0]        privLevel,
  input  logic              virtOn,
  input  logic              xlen32,
  input  logic              hasCounters,
  input  logic              hasSupervisor,
  input  logic [MASK_W-1:0] mCountEn,
  input  logic [MASK_W-1:0] hCountEn,
  input  logic [MASK_W-1:0] sCountEn,
  output logic              grantOk,
  output logic              faultIllegal,
  output logic              faultVirtual
);
  sel_t     selBus;
  verdict_t strobeBus;

  ctrGateDatapath #(
    .CSR_W(CSR_W), .MASK_W(MASK_W), .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE)
  ) dp_i (
    .clk(clk), .rst(rst), .csrAddr(csrAddr), .xlen32(xlen32),
    .mCountEn(mCountEn), .hCountEn(hCountEn), .sCountEn(sCountEn),
    .strobe(strobeBus), .selOut(selBus),
    .grantOk(grantOk), .faultIllegal(faultIllegal), .faultVirtual(faultVirtual)
  );

  ctrGateControl ctl_i (
    .reqValid(reqValid), .privLevel(privLevel), .virtOn(virtOn),
    .hasCounters(hasCounters), .hasSupervisor(hasSupervisor),
    .sel(selBus), .strobe(strobeBus)
  );

endmodule

// File: rtl/ctrGateChecker.sv
module ctrGateChecker #(
  parameter int CSR_W = 12,
  parameter int MASK_W = 32,
  parameter logic [CSR_W-1:0] LOW_BASE = 12'hC00,
  parameter logic [CSR_W-1:0] HIGH_BASE = 12'hC80
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic [CSR_W-1:0]  csrAddr,
  input logic [1:0]        privLevel,
  input logic              virtOn,
  input logic              xlen32,
  input logic              hasCounters,
  input logic [MASK_W-1:0] mCountEn,
  input logic [MASK_W-1:0] hCountEn,
  input logic              grantOk,
  input logic              faultIllegal,
  input logic              faultVirtual
);
  localparam int IDX_W = $clog2(MASK_W);

  logic             loHit;
  logic             hiHit;
  logic [IDX_W-1:0] idx;

  assign loHit = (csrAddr >= LOW_BASE) && (csrAddr <= LOW_BASE + CSR_W'(MASK_W - 1));
  assign hiHit = (csrAddr >= HIGH_BASE) && (csrAddr <= HIGH_BASE + CSR_W'(MASK_W - 1));
  assign idx   = csrAddr[IDX_W-1:0];

  p_one_verdict_r1: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> $countones({grantOk, faultIllegal, faultVirtual}) == 1);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> $countones({grantOk, faultIllegal, faultVirtual}) == 0);

  p_no_ext_r2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !hasCounters && (loHit || hiHit)) |=> faultIllegal);

  p_wide_upper_low_r5: assert property (@(posedge clk) disable iff (rst)
    (reqValid && hasCounters && hiHit && !xlen32 && privLevel != 2'd3) |=> faultIllegal);

  p_wide_upper_m_r5: assert property (@(posedge clk) disable iff (rst)
    (reqValid && hasCounters && hiHit && !xlen32 && privLevel == 2'd3) |=> grantOk);

  p_machine_first_r6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && hasCounters && loHit && privLevel != 2'd3 && !mCountEn[idx]) |=> faultIllegal);

  p_hyp_block_r7: assert property (@(posedge clk) disable iff (rst)
    (reqValid && hasCounters && loHit && privLevel != 2'd3 && mCountEn[idx]
     && virtOn && !hCountEn[idx]) |=> faultVirtual);

  p_outside_r9: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !loHit && !hiHit) |=> grantOk);

endmodule

bind counter_access_gate ctrGateChecker #(
  .CSR_W(CSR_W), .MASK_W(MASK_W), .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE)
) chk_i (
  .clk(clk), .rst(rst), .reqValid(reqValid), .csrAddr(csrAddr),
  .privLevel(privLevel), .virtOn(virtOn), .xlen32(xlen32),
  .hasCounters(hasCounters), .mCountEn(mCountEn), .hCountEn(hCountEn),
  .grantOk(grantOk), .faultIllegal(faultIllegal), .faultVirtual(faultVirtual)
);

// File: tb/counter_access_gate_tb_top.sv
module counter_access_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid;
  logic [11:0] csrAddr;
  logic [1:0]  privLevel;
  logic        virtOn;
  logic        xlen32;
  logic        hasCounters;
  logic        hasSupervisor;
  logic [31:0] mCountEn;
  logic [31:0] hCountEn;
  logic [31:0] sCountEn;
  logic        grantOk;
  logic        faultIllegal;
  logic        faultVirtual;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  counter_access_gate dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .csrAddr(csrAddr),
    .privLevel(privLevel), .virtOn(virtOn), .xlen32(xlen32),
    .hasCounters(hasCounters), .hasSupervisor(hasSupervisor),
    .mCountEn(mCountEn), .hCountEn(hCountEn), .sCountEn(sCountEn),
    .grantOk(grantOk), .faultIllegal(faultIllegal), .faultVirtual(faultVirtual)
  );

  // expected output as {grant, illegal, virtual}
  function automatic logic [2:0] refModel(
      input logic [11:0] a, input int p, input bit v, input bit x32,
      input bit hc, input bit hs, input logic [31:0] m, input logic [31:0] h,
      input logic [31:0] s, output string tag);
    int  idx;
    bit  guest;
    idx = -1;
    guest = v && (p != 3);
    if (a >= 12'hC00 && a <= 12'hC1F) begin
      idx = int'(a) - 'hC00;
    end else if (a >= 12'hC80 && a <= 12'hC9F) begin
      if (x32) idx = int'(a) - 'hC80;
      else idx = -2;
    end else begin
      tag = "R9";
      return 3'b100;
    end
    if (!hc) begin tag = "R2"; return 3'b010; end
    if (idx == -2) begin
      tag = "R5";
      return (p == 3) ? 3'b100 : 3'b010;
    end
    if (p != 3 && !m[idx]) begin tag = "R6"; return 3'b010; end
    if (guest && !h[idx]) begin tag = "R7"; return 3'b001; end
    if (hs && p == 0 && !s[idx]) begin
      tag = "R8";
      return guest ? 3'b001 : 3'b010;
    end
    tag = (p == 3) ? "R10" : ((a >= 12'hC80) ? "R4" : "R3");
    return 3'b100;
  endfunction

  task automatic checkOut(input logic [2:0] exp, input string tag);
    checks++;
    if ({grantOk, faultIllegal, faultVirtual} !== exp) begin
      errors++;
      $display("FAIL %s addr=%h priv=%0d virt=%0d x32=%0d actual=%b expected=%b",
               tag, csrAddr, privLevel, virtOn, xlen32,
               {grantOk, faultIllegal, faultVirtual}, exp);
    end
  endtask

  // apply one request at a negedge, check at the next negedge
  task automatic doReq(input logic [11:0] a, input int p, input bit v, input bit x32,
                       input bit hc, input bit hs, input logic [31:0] m,
                       input logic [31:0] h, input logic [31:0] s);
    logic [2:0] exp;
    string tag;
    csrAddr = a; privLevel = 2'(p); virtOn = v; xlen32 = x32;
    hasCounters = hc; hasSupervisor = hs;
    mCountEn = m; hCountEn = h; sCountEn = s;
    reqValid = 1'b1;
    exp = refModel(a, p, v, x32, hc, hs, m, h, s, tag);
    @(negedge clk);
    checkOut(exp, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; reqValid = 1'b1; csrAddr = 12'hC00; privLevel = 2'd3;
    virtOn = 0; xlen32 = 1; hasCounters = 1; hasSupervisor = 1;
    mCountEn = '1; hCountEn = '1; sCountEn = '1;
    repeat (3) @(negedge clk);
    checkOut(3'b000, "R1 reset");
    rst = 1'b0;

    // R3 cycle blocked by machine mask at supervisor level
    doReq(12'hC00, 1, 0, 1, 1, 1, 32'hFFFF_FFFE, '1, '1);
    // R3 event counter 31 allowed
    doReq(12'hC1F, 1, 0, 0, 1, 1, 32'h8000_0000, '1, '1);
    // R4 upper half bit 3 clear / set
    doReq(12'hC83, 0, 0, 1, 1, 1, 32'hFFFF_FFF7, '1, '1);
    doReq(12'hC83, 0, 0, 1, 1, 1, 32'h0000_0008, '1, 32'h8);
    // R5 64-bit upper half below machine and at machine
    doReq(12'hC85, 0, 0, 0, 1, 1, '1, '1, '1);
    doReq(12'hC85, 3, 0, 0, 1, 1, '0, '0, '0);
    // R6 machine and hypervisor both clear in a guest: machine wins
    doReq(12'hC02, 1, 1, 1, 1, 1, 32'h0, 32'h0, '1);
    // R7 hypervisor clear, supervisor clear, guest user: hypervisor wins
    doReq(12'hC01, 0, 1, 1, 1, 1, '1, 32'h0, 32'h0);
    // R8 user, supervisor bit clear, no guest -> illegal
    doReq(12'hC04, 0, 0, 1, 1, 1, '1, '1, 32'hFFFF_FFEF);
    // R8 guest user, supervisor clear -> virtual
    doReq(12'hC04, 0, 1, 1, 1, 1, '1, '1, 32'hFFFF_FFEF);
    // R8 no supervisor mode: mask ignored
    doReq(12'hC04, 0, 0, 1, 1, 0, '1, '1, 32'h0);
    // R6 reserved priv 2 is not user
    doReq(12'hC04, 2, 0, 1, 1, 1, '1, '1, 32'h0);
    // R2 no counter extension
    doReq(12'hC00, 3, 0, 1, 0, 1, '1, '1, '1);
    // R9 outside address with no extension
    doReq(12'h300, 0, 1, 1, 0, 1, '0, '0, '0);
    doReq(12'hCA0, 0, 0, 1, 1, 1, '0, '0, '0);
    // R10 machine with virt flag and empty masks
    doReq(12'hC10, 3, 1, 1, 1, 1, 32'h0001_0000, 32'h0, 32'h0);

    // R1 idle cycle
    reqValid = 1'b0;
    @(negedge clk);
    checkOut(3'b000, "R1 idle");

    // sweep all 64 counter addresses with sparse random state
    for (int round = 0; round < 8; round++) begin
      for (int k = 0; k < 64; k++) begin
        logic [11:0] a;
        a = (k < 32) ? 12'(12'hC00 + k) : 12'(12'hC80 + (k - 32));
        doReq(a, int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
              bit'($urandom_range(0, 1)), ($urandom_range(0, 7) != 0),
              bit'($urandom_range(0, 1)),
              $urandom & $urandom, $urandom & $urandom, $urandom & $urandom);
      end
    end
    // random non-counter addresses
    for (int k = 0; k < 32; k++) begin
      logic [11:0] a;
      a = 12'($urandom_range(0, 4095));
      doReq(a, int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), $urandom, $urandom, $urandom);
    end

    reqValid = 1'b0;
    @(negedge clk);
    checkOut(3'b000, "R1 final idle");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule